// File: doc/BRIEF.md
# Unified Polynomial and Big-Integer Multiply-Accumulate Chain

This block is a linear chain of N multiply-accumulate cells that serves polynomial arithmetic with small power-of-two coefficient moduli and multi-word unsigned integer arithmetic. At a start pulse it captures two operands of N chunks of W bits each. The held operand B stays in place across the cells. The streamed operand A enters the left end one chunk per step. Partial results move one cell to the right per step and leave the right end as a stream of W-bit result words, marked by a valid strobe.

A mode code picks the operation. The polynomial modes work on coefficients masked to CW bits, with no carry from one coefficient to the next. They are the plain product, the negacyclic wrap, and a scaled vector add or subtract. The integer modes keep each cell's overflow in that cell and add it back on the next step, so the carries ripple out through the normal data flow. Three integer modes exist: the low half of the product, the high half, and a folded form for the modulus 2^(N·W) − K. The fold multiplies each high chunk by K at the right end and adds it to the matching low chunk.

Every operation takes the same number of cycles, so the run time reveals nothing about the operand values.

Top module: `unimac_chain`

## Requirements
- R1: After reset, busy, done and r_valid are all low.
- R2: A start that is sampled while the block is idle is accepted on that clock edge. busy then stays high for exactly 2N+3 cycles in every mode. done rises on the same edge on which busy falls and lasts for one cycle.
- R3: A start that arrives while busy is high has no effect. The running operation delivers its own results and finishes on schedule.
- R4: Mode 0 gives the plain polynomial product. Operands are N chunks of W bits, and chunk i sits at bits [i·W +: W] of a_vec or b_vec. The block emits 2N−1 words r_0..r_{2N−2} in ascending order, where r_m = Σ a_i·b_{m−i} mod 2^CW.
- R5: Mode 1 gives the negacyclic product modulo X^N+1. It emits N words c_t = (Σ_{i+j=t} a_i·b_j − Σ_{i+j=t+N} a_i·b_j) mod 2^CW, for t ascending.
- R6: Mode 2 treats a_vec and b_vec as unsigned N·W-bit integers. It emits the N low W-bit chunks of their product, least significant first.
- R7: Mode 3 emits the N high W-bit chunks of the same integer product, least significant first.
- R8: Mode 4 emits N+1 chunks, least significant first, of L + K·H. Here L is the low half and H the high half of the integer product. The last chunk holds the overflow above N·W bits.
- R9: Mode 5 emits N words (acc_t + l·a_t) mod 2^CW, and mode 6 emits N words (acc_t − l·a_t) mod 2^CW. The scalar l is chunk 0 of b_vec, and acc_t is chunk t of acc_vec.
- R10: Mode code 7 behaves exactly like mode 0.
- R11: r_valid is high only while busy is high or during the done cycle. The number of valid words per operation is fixed by the mode. In modes 0, 1, 5, 6 and 7, r_data never exceeds 2^CW−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| mode | input | 3 | Operation code, captured at start |
| a_vec | input | N·W | Streamed operand, chunk 0 in the low bits |
| b_vec | input | N·W | Held operand; chunk 0 is the scalar in vector modes |
| acc_vec | input | N·W | Addend coefficients for vector modes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| r_valid | output | 1 | r_data carries a result word |
| r_data | output | W | Result word, stream order ascending |

## Verification
A single corrupted cell register or carry does not vanish. It moves toward the right end at one cell per step, so it turns up in a specific result word within at most N steps, and in the integer modes it also shifts every more significant chunk after it. A stale feedback or fold carry damages only the wrapped or folded words, which leave in the second half of the run. The checks therefore compare every emitted word and its position, using all-ones operands so that every carry path is driven. A fault in the control counter shows up as a changed busy length or a wrong word count before done.

// File: rtl/unimac_pkg.sv
package unimac_pkg;

    typedef enum logic [2:0] {
        MD_POLY = 3'd0,
        MD_NEGA = 3'd1,
        MD_ILO  = 3'd2,
        MD_IHI  = 3'd3,
        MD_IRED = 3'd4,
        MD_VADD = 3'd5,
        MD_VSUB = 3'd6
    } mac_mode_e;

    // Integer modes keep carries; every other code works on masked coefficients.
    function automatic logic mode_is_coef(input logic [2:0] m);
        return !(m == MD_ILO || m == MD_IHI || m == MD_IRED);
    endfunction

    function automatic logic mode_is_vec(input logic [2:0] m);
        return (m == MD_VADD || m == MD_VSUB);
    endfunction

endpackage

// File: rtl/unimac_cell.sv
module unimac_cell #(
    parameter int W = 17
) (
    input  logic [W-1:0]   din,
    input  logic [2*W-1:0] prod,
    input  logic [W:0]     cin,
    input  logic           coef,
    input  logic [W-1:0]   cmask,
    output logic [W-1:0]   dout,
    output logic [W:0]     cout
);
    logic [2*W:0] sum;

    always_comb begin
        sum = (2*W+1)'(din) + (2*W+1)'(prod) + (2*W+1)'(cin);
        if (coef) begin
            dout = sum[W-1:0] & cmask;
            cout = '0;
        end else begin
            dout = sum[W-1:0];
            cout = sum[2*W:W];
        end
    end
endmodule

// File: rtl/unimac_fold.sv
module unimac_fold #(
    parameter int W  = 17,
    parameter int K  = 19,
    parameter int KW = 5
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [KW:0]  cin,
    output logic [W-1:0] dout,
    output logic [KW:0]  cout
);
    localparam int FW = W + KW + 1;
    logic [FW-1:0] f;

    always_comb begin
        f    = FW'(lo) + FW'(K) * FW'(hi) + FW'(cin);
        dout = f[W-1:0];
        cout = f[FW-1:W];
    end
endmodule

// File: rtl/unimac_chain.sv
module unimac_chain
    import unimac_pkg::*;
#(
    parameter int N  = 16,
    parameter int W  = 17,
    parameter int CW = 13,
    parameter int K  = 19
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     mode,
    input  logic [N*W-1:0] a_vec,
    input  logic [N*W-1:0] b_vec,
    input  logic [N*W-1:0] acc_vec,
    output logic           busy,
    output logic           done,
    output logic           r_valid,
    output logic [W-1:0]   r_data
);
    localparam int LAST = 2 * N + 2;
    localparam int CNTW = $clog2(LAST + 1) + 1;
    localparam int KW   = $clog2(K + 1);
    localparam logic [W-1:0] CMASK = W'((64'd1 << CW) - 64'd1);

    typedef struct packed {
        logic                    busy;
        logic                    done;
        logic [CNTW-1:0]         cnt;
        logic [2:0]              md;
        logic [N*W-1:0]          a_sh;
        logic [N*W-1:0]          b;
        logic [N*W-1:0]          acc_sh;
        logic [N-1:0][2*W-1:0]   pr;
        logic [N-1:0][W-1:0]     s;
        logic [N-1:0][W:0]       cy;
        logic [N-1:0][W-1:0]     lane;
        logic [KW:0]             fcar;
        logic                    ov;
        logic [W-1:0]            od;
    } st_t;

    st_t st_q, st_d;

    logic [W-1:0]   fb;
    logic [W-1:0]   sn;
    logic           coef;
    logic [W-1:0]   cell_in  [N];
    logic [W-1:0]   cell_out [N];
    logic [W:0]     cell_cy  [N];
    logic [W-1:0]   fold_out;
    logic [KW:0]    fold_cy;

    assign sn   = st_q.s[N-1];
    assign coef = mode_is_coef(st_q.md);

    // Negated right-end word re-enters the left cell during the first N result steps.
    always_comb begin
        fb = '0;
        if (st_q.busy && st_q.md == MD_NEGA && st_q.cnt >= CNTW'(2) && st_q.cnt <= CNTW'(N + 1))
            fb = (W'(0) - sn) & CMASK;
    end

    for (genvar k = 0; k < N; k++) begin : g_cell
        if (k == 0) begin : g_left
            assign cell_in[k] = fb;
        end else begin : g_mid
            assign cell_in[k] = st_q.s[k-1];
        end
        unimac_cell #(.W(W)) u_cell (
            .din   (cell_in[k]),
            .prod  (st_q.pr[k]),
            .cin   (st_q.cy[k]),
            .coef  (coef),
            .cmask (CMASK),
            .dout  (cell_out[k]),
            .cout  (cell_cy[k])
        );
    end

    unimac_fold #(.W(W), .K(K), .KW(KW)) u_fold (
        .lo   (st_q.lane[N-1]),
        .hi   (sn),
        .cin  (st_q.fcar),
        .dout (fold_out),
        .cout (fold_cy)
    );

    always_comb begin
        int j;
        logic [W-1:0] a0;
        logic [W-1:0] accj;
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ov   = 1'b0;
        j         = int'(st_q.cnt) - 2;
        a0        = st_q.a_sh[W-1:0];
        accj      = st_q.acc_sh[W-1:0];
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
                st_d.md     = mode;
                st_d.a_sh   = a_vec;
                st_d.b      = b_vec;
                st_d.acc_sh = acc_vec;
                st_d.pr     = '0;
                st_d.s      = '0;
                st_d.cy     = '0;
                st_d.lane   = '0;
                st_d.fcar   = '0;
            end
        end else begin
            st_d.cnt  = st_q.cnt + CNTW'(1);
            st_d.a_sh = st_q.a_sh >> W;
            for (int k = 0; k < N; k++) begin
                st_d.pr[k] = {{W{1'b0}}, a0} * {{W{1'b0}}, st_q.b[(N-1-k)*W +: W]};
                if (mode_is_vec(st_q.md) && k != N - 1)
                    st_d.pr[k] = '0;
                st_d.s[k]  = cell_out[k];
                st_d.cy[k] = cell_cy[k];
            end
            if (j >= 0) begin
                for (int k = N - 1; k > 0; k--)
                    st_d.lane[k] = st_q.lane[k-1];
                st_d.lane[0] = (j < N) ? sn : '0;
                st_d.acc_sh  = st_q.acc_sh >> W;
                case (st_q.md)
                    MD_NEGA: begin
                        st_d.ov = (j >= N) && (j < 2 * N);
                        st_d.od = (W'(0) - sn) & CMASK;
                    end
                    MD_ILO: begin
                        st_d.ov = (j < N);
                        st_d.od = sn;
                    end
                    MD_IHI: begin
                        st_d.ov = (j >= N) && (j < 2 * N);
                        st_d.od = sn;
                    end
                    MD_IRED: begin
                        st_d.ov = (j >= N);
                        st_d.od = fold_out;
                        if (j >= N) st_d.fcar = fold_cy;
                    end
                    MD_VADD: begin
                        st_d.ov = (j < N);
                        st_d.od = (accj + sn) & CMASK;
                    end
                    MD_VSUB: begin
                        st_d.ov = (j < N);
                        st_d.od = (accj - sn) & CMASK;
                    end
                    default: begin
                        st_d.ov = (j < 2 * N - 1);
                        st_d.od = sn;
                    end
                endcase
            end
            if (st_q.cnt == CNTW'(LAST)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign r_valid = st_q.ov;
    assign r_data  = st_q.od;
endmodule

// File: rtl/unimac_chk.sv
module unimac_chk #(
    parameter int N  = 16,
    parameter int W  = 17,
    parameter int CW = 13
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [2:0]   mode,
    input logic         busy,
    input logic         done,
    input logic         r_valid,
    input logic [W-1:0] r_data
);
    localparam int SPAN = 2 * N + 3;
    localparam logic [W-1:0] CMASK = W'((64'd1 << CW) - 64'd1);

    logic [2:0] md_l;
    int         bcnt_q;
    int         vcnt_q;

    function automatic int words_for(input logic [2:0] m);
        case (m)
            3'd1, 3'd2, 3'd3, 3'd5, 3'd6: return N;
            3'd4:                         return N + 1;
            default:                      return 2 * N - 1;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_l   <= '0;
            bcnt_q <= 0;
            vcnt_q <= 0;
        end else begin
            bcnt_q <= busy ? bcnt_q + 1 : 0;
            if (start && !busy) begin
                md_l   <= mode;
                vcnt_q <= 0;
            end else if (r_valid) begin
                vcnt_q <= vcnt_q + 1;
            end
        end
    end

    // R2: accepted start raises busy on the next edge
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    // R2: busy length is the same fixed span in every mode
    a_r2_span: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt_q == SPAN && done));

    // R2: done is a single-cycle pulse outside busy
    a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R3: a start during an operation cannot end it early
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && bcnt_q < SPAN - 1 |=> busy);

    // R11: results appear only inside an operation
    a_r11_window: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> (busy || done));

    // R11: word count per operation follows the captured mode
    a_r11_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vcnt_q + (r_valid ? 1 : 0)) == words_for(md_l));

    // R11: coefficient modes stay inside the coefficient range
    a_r11_range: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid && !(md_l == 3'd2 || md_l == 3'd3 || md_l == 3'd4) |-> r_data <= CMASK);
endmodule

bind unimac_chain unimac_chk #(.N(N), .W(W), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .busy    (busy),
    .done    (done),
    .r_valid (r_valid),
    .r_data  (r_data)
);

// File: tb/tb_unimac_chain.sv
module tb_unimac_chain;
    localparam int N   = 16;
    localparam int W   = 17;
    localparam int CW  = 13;
    localparam int K   = 19;
    localparam int NW  = N * W;
    localparam int CYC = 2 * N + 3;
    localparam longint CM = (64'd1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic [NW-1:0] a_vec = '0;
    logic [NW-1:0] b_vec = '0;
    logic [NW-1:0] acc_vec = '0;
    logic          busy, done, r_valid;
    logic [W-1:0]  r_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [W-1:0]    got  [0:2*N];
    logic [W-1:0]    expv [0:2*N];
    int              ngot, nexp, ncyc;
    logic [2*NW-1:0] P, E;

    always #10 clk = ~clk;

    unimac_chain #(.N(N), .W(W), .CW(CW), .K(K)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .a_vec(a_vec), .b_vec(b_vec), .acc_vec(acc_vec),
        .busy(busy), .done(done), .r_valid(r_valid), .r_data(r_data)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint ch(input logic [NW-1:0] v, input int i);
        return longint'(v[i*W +: W]);
    endfunction

    function automatic logic [NW-1:0] gen(input int seed, input longint mask);
        logic [NW-1:0] v;
        logic [31:0]   x;
        v = '0;
        x = 32'(seed);
        for (int i = 0; i < N; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            v[i*W +: W] = W'(longint'(x[30:14]) & mask);
        end
        return v;
    endfunction

    task automatic run_op(input logic [2:0] m, input logic [NW-1:0] a, input logic [NW-1:0] b,
                          input logic [NW-1:0] c, input bit inj);
        @(negedge clk);
        mode = m; a_vec = a; b_vec = b; acc_vec = c; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        ngot = 0;
        ncyc = 0;
        while (ncyc < 200) begin
            @(posedge clk);
            ncyc++;
            @(negedge clk);
            if (inj && ncyc == 5) begin
                start = 1'b1; mode = 3'd2; a_vec = '1; b_vec = '1;
            end else if (inj && ncyc == 6) begin
                start = 1'b0;
            end
            if (r_valid && ngot <= 2 * N) begin
                got[ngot] = r_data;
                ngot++;
            end
            if (done) break;
        end
        start = 1'b0;
    endtask

    task automatic compare(input string req);
        check("R2", {req, " cycles to done"}, ncyc, CYC);
        check(req, "word count", ngot, nexp);
        for (int i = 0; i < nexp && i < ngot; i++)
            check(req, $sformatf("word %0d", i), longint'(got[i]), longint'(expv[i]));
    endtask

    function automatic void exp_poly(input logic [NW-1:0] a, input logic [NW-1:0] b);
        for (int m = 0; m < 2 * N - 1; m++) begin
            longint s = 0;
            for (int i = 0; i < N; i++)
                if (m - i >= 0 && m - i < N) s += ch(a, i) * ch(b, m - i);
            expv[m] = W'(s & CM);
        end
        nexp = 2 * N - 1;
    endfunction

    task automatic t_reset();
        check("R1", "busy after reset", longint'(busy), 0);
        check("R1", "done after reset", longint'(done), 0);
        check("R1", "r_valid after reset", longint'(r_valid), 0);
    endtask

    task automatic t_poly(input logic [NW-1:0] a, input logic [NW-1:0] b, input logic [2:0] code, input string req);
        exp_poly(a, b);
        run_op(code, a, b, '0, 1'b0);
        compare(req);
    endtask

    task automatic t_nega(input logic [NW-1:0] a, input logic [NW-1:0] b);
        for (int t = 0; t < N; t++) begin
            longint s = 0;
            for (int i = 0; i < N; i++)
                for (int jj = 0; jj < N; jj++) begin
                    if (i + jj == t)     s += ch(a, i) * ch(b, jj);
                    if (i + jj == t + N) s -= ch(a, i) * ch(b, jj);
                end
            expv[t] = W'(s & CM);
        end
        nexp = N;
        run_op(3'd1, a, b, '0, 1'b0);
        compare("R5");
    endtask

    task automatic t_int(input logic [NW-1:0] a, input logic [NW-1:0] b);
        P = {{NW{1'b0}}, a} * {{NW{1'b0}}, b};
        for (int i = 0; i < N; i++) expv[i] = P[i*W +: W];
        nexp = N;
        run_op(3'd2, a, b, '0, 1'b0);
        compare("R6");
        for (int i = 0; i < N; i++) expv[i] = P[(N+i)*W +: W];
        run_op(3'd3, a, b, '0, 1'b0);
        compare("R7");
    endtask

    task automatic t_red(input logic [NW-1:0] a, input logic [NW-1:0] b);
        P = {{NW{1'b0}}, a} * {{NW{1'b0}}, b};
        E = {{NW{1'b0}}, P[NW-1:0]} + (2*NW)'(K) * (P >> NW);
        for (int i = 0; i <= N; i++) expv[i] = E[i*W +: W];
        nexp = N + 1;
        run_op(3'd4, a, b, '0, 1'b0);
        compare("R8");
        check("R8", "bits above final chunk", longint'(E >> ((N+1)*W) != 0), 0);
    endtask

    task automatic t_vec(input logic [NW-1:0] a, input logic [NW-1:0] b, input logic [NW-1:0] c, input bit sub);
        longint l = ch(b, 0);
        for (int t = 0; t < N; t++)
            expv[t] = sub ? W'((ch(c, t) - l * ch(a, t)) & CM) : W'((ch(c, t) + l * ch(a, t)) & CM);
        nexp = N;
        run_op(sub ? 3'd6 : 3'd5, a, b, c, 1'b0);
        compare("R9");
    endtask

    task automatic t_busy_start(input logic [NW-1:0] a, input logic [NW-1:0] b);
        exp_poly(a, b);
        run_op(3'd0, a, b, '0, 1'b1);
        compare("R3");
        @(negedge clk);
        check("R3", "idle after run with stray start", longint'(busy), 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] pa, pb, pc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        pa = gen(7, CM);
        pb = gen(99, CM);
        pc = gen(1234, CM);
        t_poly(pa, pb, 3'd0, "R4");
        t_poly(gen(3, CM), gen(4, CM), 3'd0, "R4");
        t_poly({N{W'(CM)}}, {N{W'(CM)}}, 3'd0, "R4");
        t_poly(pa, pb, 3'd7, "R10");
        t_nega(pa, pb);
        t_nega({N{W'(CM)}}, gen(5, CM));
        t_int('1, '1);
        t_int(gen(11, (64'd1 << W) - 1), gen(12, (64'd1 << W) - 1));
        t_red('1, '1);
        t_red(gen(21, (64'd1 << W) - 1), gen(22, (64'd1 << W) - 1));
        t_vec(pa, pb, pc, 1'b0);
        t_vec(pa, pb, pc, 1'b1);
        t_busy_start(gen(31, CM), gen(32, CM));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule